// File: doc/BRIEF.md
# Interrupt Coalescing Event Timer

This block merges receive-completion and transmit-completion events into a single interrupt request. The request is raised only after a programmed number of events has been seen, or after a maximum delay has elapsed since the first event, whichever comes first. This lets a service routine handle several completions in one pass.

A 16-bit configuration word supplies an event-count field and a maximum-delay field. When the host clears either status flag, both internal counters are reloaded from the word and the delay timer is disarmed. The first enabled event arms the timer. While armed, the timer counts down one step for each pulse on a free-running tick input, which nominally pulses once every 10 microseconds. The block therefore needs no knowledge of the clock frequency.

Top module: `irq_coalesce`

## Requirements
- R1: After reset, `irq`, `rx_flag` and `tx_flag` are 0, the event counter holds zero and the timer is disarmed. As a result, any enabled event seen before the first clear strobe raises `irq` on the following cycle.
- R2: The configuration word places the event count in bits [4:0] and the maximum delay in bits [15:5]. A pulse on `clr_rx` or `clr_tx` loads the counter from the count field and the timer from the delay field, disarms the timer, and drops `irq` on the next cycle.
- R3: An enabled receive event and an enabled transmit event each take one off the event counter. When both occur in the same cycle, the counter drops by two. The counter saturates at zero and does not wrap.
- R4: `irq` goes high on the cycle after an enabled event leaves the event counter at zero. With a count field of 0, the first enabled event after a clear raises it.
- R5: The first enabled event arms the timer. Each `tick_10us` pulse that arrives while the timer was already armed at the start of the cycle takes one off the timer, saturating at zero. `irq` goes high on the cycle after a tick leaves the timer at zero. A tick in the same cycle as the arming event does not count.
- R6: Once `irq` is high, it stays high until a clear strobe. Further events and ticks do not lower it.
- R7: An enabled event sets its own status flag on the next cycle. `clr_rx` clears only `rx_flag` and `clr_tx` clears only `tx_flag`. An event in the same cycle as a clear still sets its flag and counts against the freshly reloaded values.
- R8: A completion pulse whose enable (`rx_ie` or `tx_ie`) is 0 sets no flag, does not change the counter and does not arm the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 16 | Coalescing configuration: [4:0] event count, [15:5] maximum delay |
| rx_done | input | 1 | Single-cycle receive completion pulse |
| tx_done | input | 1 | Single-cycle transmit completion pulse |
| rx_ie | input | 1 | Receive interrupt enable |
| tx_ie | input | 1 | Transmit interrupt enable |
| clr_rx | input | 1 | Host strobe clearing the receive flag |
| clr_tx | input | 1 | Host strobe clearing the transmit flag |
| tick_10us | input | 1 | Single-cycle time-base pulse |
| irq | output | 1 | Coalesced interrupt request |
| rx_flag | output | 1 | Receive interrupt status flag |
| tx_flag | output | 1 | Transmit interrupt status flag |

## Verification
The hardest case to reach is the boundary where the timer's own arming event and a tick coincide. This case sits alongside the saturation cases: two events arriving against a count of one, and a zero delay field.

The bench reaches these by sweeping the count field and the delay field over small values. Each sweep starts with a fresh clear. The bench then drives exactly one event, tick or event pair per cycle and predicts the interrupt cycle arithmetically from the field value.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

    typedef struct packed {
        logic irq;
        logic [1:0] flag;
    } top_state_t;

endpackage

// File: rtl/ico_evt_ctr.sv
module ico_evt_ctr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [1:0]   dec_n,
    output logic         hit
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] base;
    logic [W-1:0] dec_ext;

    always_comb begin
        base    = load ? load_val : cnt_q;
        dec_ext = {{(W-2){1'b0}}, dec_n};
        if (base > dec_ext) begin
            cnt_d = base - dec_ext;
        end else begin
            cnt_d = '0;
        end
        hit = (dec_n != 2'd0) && (cnt_d == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/ico_dly_tmr.sv
module ico_dly_tmr #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         arm,
    input  logic         tick,
    output logic         hit
);
    logic [W-1:0] tmr_d, tmr_q;
    logic         arm_d, arm_q;
    logic [W-1:0] base;
    logic         base_arm;
    logic         step;

    always_comb begin
        base     = load ? load_val : tmr_q;
        base_arm = load ? 1'b0 : arm_q;
        step     = tick && base_arm;
        if (step && (base != '0)) begin
            tmr_d = base - 1'b1;
        end else begin
            tmr_d = base;
        end
        arm_d = base_arm || arm;
        hit   = step && (tmr_d == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
            arm_q <= 1'b0;
        end else begin
            tmr_q <= tmr_d;
            arm_q <= arm_d;
        end
    end
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
    import irq_coal_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int TMR_W = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W+TMR_W-1:0] cfg_word,
    input  logic                   rx_done,
    input  logic                   tx_done,
    input  logic                   rx_ie,
    input  logic                   tx_ie,
    input  logic                   clr_rx,
    input  logic                   clr_tx,
    input  logic                   tick_10us,
    output logic                   irq,
    output logic                   rx_flag,
    output logic                   tx_flag
);
    localparam int CFG_W = CNT_W + TMR_W;
    localparam int NSRC  = 2;

    top_state_t st_d, st_q;

    logic [NSRC-1:0] evt;
    logic [NSRC-1:0] clr;
    logic            any_clr;
    logic [1:0]      n_evt;
    logic            cnt_hit, tmr_hit;
    logic [CNT_W-1:0] cnt_field;
    logic [TMR_W-1:0] tmr_field;

    assign cnt_field = cfg_word[CNT_W-1:0];
    assign tmr_field = cfg_word[CFG_W-1:CNT_W];
    assign evt       = {tx_done && tx_ie, rx_done && rx_ie};
    assign clr       = {clr_tx, clr_rx};
    assign any_clr   = |clr;
    assign n_evt     = {1'b0, evt[0]} + {1'b0, evt[1]};

    ico_evt_ctr #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (any_clr),
        .load_val (cnt_field),
        .dec_n    (n_evt),
        .hit      (cnt_hit)
    );

    ico_dly_tmr #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (any_clr),
        .load_val (tmr_field),
        .arm      (|evt),
        .tick     (tick_10us),
        .hit      (tmr_hit)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSRC; i++) begin
            st_d.flag[i] = (st_q.flag[i] && !clr[i]) || evt[i];
        end
        st_d.irq = (st_q.irq && !any_clr) || cnt_hit || tmr_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq     = st_q.irq;
    assign rx_flag = st_q.flag[0];
    assign tx_flag = st_q.flag[1];
endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_done,
    input logic tx_done,
    input logic rx_ie,
    input logic tx_ie,
    input logic clr_rx,
    input logic clr_tx,
    input logic tick_10us,
    input logic irq,
    input logic rx_flag,
    input logic tx_flag
);
    // R2
    clr_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_rx || clr_tx) && !(rx_done && rx_ie) && !(tx_done && tx_ie)) |=> !irq);

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_rx && !clr_tx) |=> irq);

    // R7
    rx_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_ie) |=> rx_flag);

    // R7
    tx_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && tx_ie) |=> tx_flag);

    // R8
    rx_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_flag && !(rx_done && rx_ie)) |=> !rx_flag);

    // R4
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((rx_done && rx_ie) || (tx_done && tx_ie) || tick_10us));
endmodule

bind irq_coalesce irq_coalesce_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_done   (rx_done),
    .tx_done   (tx_done),
    .rx_ie     (rx_ie),
    .tx_ie     (tx_ie),
    .clr_rx    (clr_rx),
    .clr_tx    (clr_tx),
    .tick_10us (tick_10us),
    .irq       (irq),
    .rx_flag   (rx_flag),
    .tx_flag   (tx_flag)
);

// File: tb/irq_coalesce_tb_top.sv
module irq_coalesce_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] cfg_word = '0;
    logic rx_done = 0, tx_done = 0, rx_ie = 1, tx_ie = 1;
    logic clr_rx = 0, clr_tx = 0, tick_10us = 0;
    logic irq, rx_flag, tx_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_coalesce dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .rx_done(rx_done), .tx_done(tx_done), .rx_ie(rx_ie), .tx_ie(tx_ie),
        .clr_rx(clr_rx), .clr_tx(clr_tx), .tick_10us(tick_10us),
        .irq(irq), .rx_flag(rx_flag), .tx_flag(tx_flag)
    );

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // one clock with the given pulses; outputs are sampled 2 ns after the edge
    task automatic cyc(logic rx, logic tx, logic tk, logic cr, logic ct);
        rx_done = rx; tx_done = tx; tick_10us = tk; clr_rx = cr; clr_tx = ct;
        @(posedge clk);
        #2;
        rx_done = 0; tx_done = 0; tick_10us = 0; clr_rx = 0; clr_tx = 0;
    endtask

    function automatic logic [15:0] cfg(int c, int d);
        return {d[10:0], c[4:0]};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 rx_flag", rx_flag, 0);
        check("R1 tx_flag", tx_flag, 0);
        rst_n = 1;
        cyc(0, 0, 0, 0, 0);
        // R1 event before any clear interrupts at once
        cyc(1, 0, 0, 0, 0);
        check("R1 early event", irq, 1);
        check("R7 rx flag", rx_flag, 1);
        check("R7 tx flag untouched", tx_flag, 0);

        // R4 / R3 count sweep
        for (int c = 0; c < 7; c++) begin
            cfg_word = cfg(c, 2047);
            cyc(0, 0, 0, 1, 1);
            check("R2 irq dropped", irq, 0);
            check("R2 rx flag cleared", rx_flag, 0);
            for (int i = 1; i <= 8; i++) begin
                cyc(i % 2, (i + 1) % 2, 0, 0, 0);
                check("R4 count threshold", irq, (i >= ((c == 0) ? 1 : c)));
            end
        end

        // R5 delay sweep
        for (int d = 0; d < 7; d++) begin
            cfg_word = cfg(31, d);
            cyc(0, 0, 0, 1, 0);
            cyc(0, 0, 1, 0, 0);
            check("R5 tick while disarmed", irq, 0);
            cyc(0, 1, 1, 0, 0);
            check("R5 arming tick ignored", irq, 0);
            for (int j = 1; j <= 8; j++) begin
                cyc(0, 0, 1, 0, 0);
                check("R5 delay threshold", irq, (j >= ((d == 0) ? 1 : d)));
            end
            cyc(0, 0, 0, 0, 0);
            check("R6 irq held", irq, 1);
        end

        // R3 dual events and saturation
        for (int c = 1; c < 7; c++) begin
            cfg_word = cfg(c, 2047);
            cyc(0, 0, 0, 0, 1);
            for (int p = 1; p <= 4; p++) begin
                cyc(1, 1, 0, 0, 0);
                check("R3 dual decrement", irq, (2 * p >= c));
            end
        end

        // R8 disabled source
        cfg_word = cfg(1, 1);
        cyc(0, 0, 0, 1, 1);
        rx_ie = 0;
        cyc(1, 0, 0, 0, 0);
        check("R8 no flag", rx_flag, 0);
        check("R8 no count", irq, 0);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 1, 0, 0);
        check("R8 no arming", irq, 0);
        cyc(0, 1, 0, 0, 0);
        check("R8 other source counts", irq, 1);
        rx_ie = 1;

        // R7 event in same cycle as clear
        cfg_word = cfg(2, 2047);
        cyc(1, 0, 0, 1, 1);
        check("R7 flag survives clear", rx_flag, 1);
        check("R7 tx flag cleared", tx_flag, 0);
        check("R7 irq after reload", irq, 0);
        cyc(0, 1, 0, 0, 0);
        check("R7 counted against reload", irq, 1);
        check("R7 tx flag set", tx_flag, 1);
        cyc(0, 0, 0, 0, 1);
        check("R7 clr_tx keeps rx flag", rx_flag, 1);
        check("R7 clr_tx clears tx flag", tx_flag, 0);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule